// File: doc/BRIEF.md
# DMA Bus-Sizing Transfer Sequencer

This block carries out a single DMA move of one unit, 1, 2 or 4 bytes wide, from a source byte address to a destination byte address. The source side and the destination side can each sit on an 8-bit or a 16-bit data bus, and a configuration bit per side says which. The sequencer cuts the unit into as many halfword or byte bus cycles as each side's width needs. It reads the whole unit into a 32-bit staging register first and then writes it out.

Addresses are never realigned. When either address breaks the alignment rule for the chosen size, the block raises an error and finishes at once without touching the bus. Otherwise it raises a bus request, waits for the grant, runs all read cycles and then all write cycles, and signals completion with a one-cycle done pulse. Each bus cycle lasts one clock, and read data is taken at the end of the read cycle.

Top module: `dss_size_seq`

## Requirements
- R1: The size code on `size_i` selects the unit length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is treated as an alignment error.
- R2: On an error the block produces no bus cycle and never raises `req_o`. It asserts `done_o` together with `err_o` in the cycle after `start_i` is sampled.
- R3: A 1-byte unit accepts any address. A 2-byte unit needs both addresses even. A 4-byte unit needs both addresses to be multiples of 4. Any other case is an error.
- R4: On a 16-bit side a 2-byte unit takes one halfword cycle and a 4-byte unit takes two. On an 8-bit side the unit takes one byte cycle per byte. The cycles on each side run at ascending addresses, starting at the base address.
- R5: Every read cycle of a transfer comes before its first write cycle, and `rd_o` and `wr_o` are never high together.
- R6: The data is little-endian. The byte read from source address A+i is written to destination address D+i.
- R7: `be_o[1]` is the upper lane (`data[15:8]`) and `be_o[0]` is the lower lane (`data[7:0]`). A halfword cycle on a 16-bit side drives `be_o`=11. A byte cycle on a 16-bit side drives 10 at an odd address and 01 at an even address, with the byte carried on that lane. On an 8-bit side `be_o`=01 and the data is on `data[7:0]`.
- R8: `req_o` rises in the cycle after a valid start. No bus cycle happens before `gnt_i` is seen high. `req_o` is low in the `done_o` cycle.
- R9: `done_o` is a one-cycle pulse. `start_i` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (sampled while idle) |
| size_i | input | 2 | Unit size code |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| src_wide_i | input | 1 | Source bus is 16 bit (1) or 8 bit (0) |
| dst_wide_i | input | 1 | Destination bus is 16 bit (1) or 8 bit (0) |
| gnt_i | input | 1 | Bus grant |
| rdata_i | input | 16 | Read data bus |
| req_o | output | 1 | Bus request |
| cs_o | output | 1 | Chip select, high during every bus cycle |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Bus byte address |
| be_o | output | 2 | Byte-lane strobes |
| wdata_o | output | 16 | Write data bus |
| done_o | output | 1 | Transfer finished (one-cycle pulse) |
| err_o | output | 1 | Alignment error, valid with `done_o` |

## Verification
The address-ordering property assumes that a unit never wraps past the top of the address space. The stimulus keeps source addresses below 128 and destination addresses in 128..251 of a 256-byte memory model, so no wrap can occur. The properties also assume that `gnt_i`, once given, stays high until `done_o`, and that `rdata_i` is valid during each read cycle. The bench raises the grant only after a random delay and holds it to the end. Its memory model drives read data combinationally from the address.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_DONE} state_e;
endpackage

// File: rtl/dss_align_chk.sv
module dss_align_chk
  import dss_pkg::*;
#(
  parameter int AW = 16
) (
  input  size_e         size_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          err_o
);
  function automatic logic misal(input logic [AW-1:0] a, input size_e s);
    case (s)
      SZ_1:    misal = 1'b0;
      SZ_2:    misal = a[0];
      SZ_4:    misal = |a[1:0];
      default: misal = 1'b1;
    endcase
  endfunction

  assign err_o = misal(src_addr_i, size_i) | misal(dst_addr_i, size_i);
endmodule

// File: rtl/dss_beat_plan.sv
module dss_beat_plan
  import dss_pkg::*;
#(
  parameter int OW = 3
) (
  input  size_e         size_i,
  input  logic          wide_i,
  output logic [OW-1:0] nbytes_o,
  output logic [OW-1:0] step_o
);
  always_comb begin
    case (size_i)
      SZ_2:    nbytes_o = OW'(2);
      SZ_4:    nbytes_o = OW'(4);
      default: nbytes_o = OW'(1);
    endcase
    // halfword beats only when the side is 16 bit and the unit is wider than a byte
    step_o = (wide_i && size_i != SZ_1) ? OW'(2) : OW'(1);
  end
endmodule

// File: rtl/dss_stage.sv
module dss_stage #(
  parameter int UB = 4,
  localparam int SW = UB * 8,
  localparam int XW = $clog2(UB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          wide_i,
  input  logic          hw_i,
  input  logic [XW-1:0] off_i,
  input  logic          lsb_i,
  input  logic [15:0]   rdata_i,
  output logic [1:0]    be_o,
  output logic [15:0]   wdata_o
);
  logic [SW-1:0] stage_q;
  logic [7:0]    byte_w;
  logic          upper;

  assign upper  = wide_i & lsb_i;
  assign byte_w = stage_q[8*off_i +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (cap_i) begin
      if (hw_i) stage_q[8*off_i +: 16] <= rdata_i;
      else      stage_q[8*off_i +: 8]  <= upper ? rdata_i[15:8] : rdata_i[7:0];
    end
  end

  always_comb begin
    if (!wide_i)   be_o = 2'b01;
    else if (hw_i) be_o = 2'b11;
    else           be_o = lsb_i ? 2'b10 : 2'b01;
    if (hw_i)       wdata_o = stage_q[8*off_i +: 16];
    else if (upper) wdata_o = {byte_w, 8'h00};
    else            wdata_o = {8'h00, byte_w};
  end
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  size_e         size_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          src_wide_i,
  input  logic          dst_wide_i,
  input  logic          align_err_i,
  input  logic          gnt_i,
  output size_e         size_o,
  output logic          sw_o,
  output logic          dw_o,
  input  logic [OW-1:0] nbytes_i,
  input  logic [OW-1:0] src_step_i,
  input  logic [OW-1:0] dst_step_i,
  output logic          req_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [OW-1:0] off_o,
  output logic          cur_wide_o,
  output logic          cur_hw_o,
  output logic          done_o,
  output logic          err_o
);
  state_e        st_q;
  logic [AW-1:0] src_q, dst_q;
  logic [OW-1:0] off_q, off_n, step;
  logic          err_q;
  logic          last;

  assign step  = (st_q == ST_RD) ? src_step_i : dst_step_i;
  assign off_n = off_q + step;
  assign last  = off_n >= nbytes_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      size_o <= SZ_1;
      sw_o   <= 1'b0;
      dw_o   <= 1'b0;
      off_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          src_q  <= src_addr_i;
          dst_q  <= dst_addr_i;
          size_o <= size_i;
          sw_o   <= src_wide_i;
          dw_o   <= dst_wide_i;
          off_q  <= '0;
          err_q  <= align_err_i;
          st_q   <= align_err_i ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (gnt_i) st_q <= ST_RD;
        ST_RD: begin
          off_q <= last ? '0 : off_n;
          if (last) st_q <= ST_WR;
        end
        ST_WR: begin
          off_q <= last ? '0 : off_n;
          if (last) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = st_q inside {ST_REQ, ST_RD, ST_WR};
  assign rd_o       = st_q == ST_RD;
  assign wr_o       = st_q == ST_WR;
  assign addr_o     = (rd_o ? src_q : dst_q) + AW'(off_q);
  assign off_o      = off_q;
  assign cur_wide_o = rd_o ? sw_o : dw_o;
  assign cur_hw_o   = step == OW'(2);
  assign done_o     = st_q == ST_DONE;
  assign err_o      = done_o & err_q;
endmodule

// File: rtl/dss_size_seq.sv
module dss_size_seq
  import dss_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          src_wide_i,
  input  logic          dst_wide_i,
  input  logic          gnt_i,
  input  logic [15:0]   rdata_i,
  output logic          req_o,
  output logic          cs_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    be_o,
  output logic [15:0]   wdata_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int UB = 4;
  localparam int OW = $clog2(UB) + 1;

  size_e         size_in, size_q;
  logic          align_err, sw_q, dw_q, cur_wide, cur_hw;
  logic [OW-1:0] nbytes, src_step, dst_step, off, nb_unused;

  assign size_in = size_e'(size_i);

  dss_align_chk #(.AW(AW)) u_align (
    .size_i(size_in), .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .err_o(align_err)
  );

  dss_beat_plan #(.OW(OW)) u_plan_src (
    .size_i(size_q), .wide_i(sw_q), .nbytes_o(nbytes), .step_o(src_step)
  );

  dss_beat_plan #(.OW(OW)) u_plan_dst (
    .size_i(size_q), .wide_i(dw_q), .nbytes_o(nb_unused), .step_o(dst_step)
  );

  dss_ctrl #(.AW(AW), .OW(OW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .size_i(size_in), .src_addr_i, .dst_addr_i,
    .src_wide_i, .dst_wide_i, .align_err_i(align_err), .gnt_i,
    .size_o(size_q), .sw_o(sw_q), .dw_o(dw_q),
    .nbytes_i(nbytes), .src_step_i(src_step), .dst_step_i(dst_step),
    .req_o, .rd_o, .wr_o, .addr_o, .off_o(off),
    .cur_wide_o(cur_wide), .cur_hw_o(cur_hw), .done_o, .err_o
  );

  dss_stage #(.UB(UB)) u_stage (
    .clk_i, .rst_ni, .cap_i(rd_o), .wide_i(cur_wide), .hw_i(cur_hw),
    .off_i(off[OW-2:0]), .lsb_i(addr_o[0]), .rdata_i, .be_o, .wdata_o
  );

  assign cs_o = rd_o | wr_o;
endmodule

// File: rtl/dss_sva.sv
module dss_sva #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    size_i,
  input logic [AW-1:0] src_addr_i,
  input logic [AW-1:0] dst_addr_i,
  input logic          src_wide_i,
  input logic          dst_wide_i,
  input logic          gnt_i,
  input logic [15:0]   rdata_i,
  input logic          req_o,
  input logic          cs_o,
  input logic          rd_o,
  input logic          wr_o,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    be_o,
  input logic [15:0]   wdata_o,
  input logic          done_o,
  input logic          err_o
);
  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !cs_o && !req_o && !$past(cs_o));
  assert_rd_wr_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  assert_no_read_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !rd_o);
  assert_addr_ascends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o) && rd_o == $past(rd_o)) |-> addr_o > $past(addr_o));
  assert_lane_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> be_o != 2'b00);
  assert_cycle_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> req_o);
  assert_req_low_at_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind dss_size_seq dss_sva #(.AW(AW)) u_sva (.*);

// File: tb/sim_dss_size_seq.sv
module sim_dss_size_seq;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start, src_w, dst_w, gnt;
  logic [1:0]    size;
  logic [AW-1:0] src_a, dst_a;
  logic [15:0]   rdata;
  logic          req, cs, rd, wr, done, err;
  logic [AW-1:0] addr;
  logic [1:0]    be;
  logic [15:0]   wdata;

  dss_size_seq #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size),
    .src_addr_i(src_a), .dst_addr_i(dst_a), .src_wide_i(src_w), .dst_wide_i(dst_w),
    .gnt_i(gnt), .rdata_i(rdata), .req_o(req), .cs_o(cs), .rd_o(rd), .wr_o(wr),
    .addr_o(addr), .be_o(be), .wdata_o(wdata), .done_o(done), .err_o(err)
  );

  logic [7:0] mem [0:255];
  int total = 0, bad = 0;
  int n_rd, n_wr, lane_bad, order_bad, grant_bad, wr_seen, exp_nb;

  // combinational memory model, little-endian on the 16-bit bus
  always_comb begin
    if (src_w) rdata = {mem[{addr[7:1], 1'b1}], mem[{addr[7:1], 1'b0}]};
    else       rdata = {8'h00, mem[addr[7:0]]};
  end

  function automatic logic [1:0] exp_be(input logic w, input int nb, input logic lsb);
    if (!w) return 2'b01;
    if (nb > 1) return 2'b11;
    return lsb ? 2'b10 : 2'b01;
  endfunction

  always @(negedge clk) begin
    if (cs && !gnt) grant_bad++;
    if (rd) begin
      n_rd++;
      if (wr_seen != 0) order_bad++;
      if (be != exp_be(src_w, exp_nb, addr[0])) lane_bad++;
    end
    if (wr) begin
      n_wr++;
      wr_seen = 1;
      if (be != exp_be(dst_w, exp_nb, addr[0])) lane_bad++;
      if (dst_w) begin
        if (be[1]) mem[{addr[7:1], 1'b1}] = wdata[15:8];
        if (be[0]) mem[{addr[7:1], 1'b0}] = wdata[7:0];
      end else begin
        mem[addr[7:0]] = wdata[7:0];
      end
    end
  end

  task automatic chk(input logic ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int nbytes_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic misal(input logic [AW-1:0] a, input logic [1:0] s);
    return (s == 2'd3) || (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 2'b00);
  endfunction

  task automatic xfer(input logic [1:0] s, input logic [AW-1:0] sa, input logic [AW-1:0] da,
                      input logic sw, input logic dw, input int gdly, input logic poke);
    logic [7:0] src_snap [0:3];
    logic [7:0] dst_snap [0:3];
    int nb, ecyc_r, ecyc_w, waited;
    logic e_err;
    nb = nbytes_of(s);
    e_err = misal(sa, s) || misal(da, s);
    ecyc_r = e_err ? 0 : ((sw && nb > 1) ? nb / 2 : nb);
    ecyc_w = e_err ? 0 : ((dw && nb > 1) ? nb / 2 : nb);
    for (int i = 0; i < 4; i++) begin
      src_snap[i] = mem[8'(sa + AW'(i))];
      dst_snap[i] = mem[8'(da + AW'(i))];
    end
    @(negedge clk);
    n_rd = 0; n_wr = 0; lane_bad = 0; order_bad = 0; grant_bad = 0; wr_seen = 0;
    exp_nb = (s == 2'd3) ? 1 : nb;
    size = s; src_a = sa; dst_a = da; src_w = sw; dst_w = dw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!e_err) begin
      chk(req == 1'b1, "R8 req after start", int'(req), 1);
      for (int i = 0; i < gdly; i++) begin
        if (poke && i == 0) begin
          start = 1'b1; size = 2'd3; src_a = 16'h0001; // R9: must be ignored
        end
        @(negedge clk);
        start = 1'b0;
      end
      gnt = 1'b1;
    end
    waited = 0;
    while (!done && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R9 done reached", int'(done), 1);
    chk(err == e_err, "R1 R2 R3 error flag", int'(err), int'(e_err));
    chk(req == 1'b0, "R8 req low at done", int'(req), 0);
    chk(n_rd == ecyc_r, "R4 read cycles", n_rd, ecyc_r);
    chk(n_wr == ecyc_w, "R4 write cycles", n_wr, ecyc_w);
    chk(lane_bad == 0, "R7 lane strobes", lane_bad, 0);
    chk(order_bad == 0, "R5 reads before writes", order_bad, 0);
    chk(grant_bad == 0, "R8 cycle before grant", grant_bad, 0);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] got, want;
      got  = mem[8'(da + AW'(i))];
      want = (!e_err && i < nb) ? src_snap[i] : dst_snap[i];
      chk(got == want, "R6 destination byte", int'(got), int'(want));
    end
    gnt = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    start = 0; size = 0; src_a = 0; dst_a = 0; src_w = 0; dst_w = 0; gnt = 0;
    repeat (3) @(negedge clk);
    chk(req == 1'b0 && cs == 1'b0 && done == 1'b0, "R8 reset state", int'({req, cs, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    xfer(2'd1, 16'h0010, 16'h0090, 1'b1, 1'b0, 1, 1'b0); // 16->8, 2 bytes
    xfer(2'd2, 16'h0020, 16'h00A1, 1'b0, 1'b1, 0, 1'b0); // misaligned dst, R3
    xfer(2'd2, 16'h0024, 16'h00A4, 1'b1, 1'b1, 2, 1'b1); // R9 poke during wait
    xfer(2'd2, 16'h0030, 16'h00B0, 1'b0, 1'b0, 0, 1'b0);
    xfer(2'd0, 16'h0033, 16'h00C5, 1'b1, 1'b1, 1, 1'b0); // odd byte lanes, R7
    xfer(2'd0, 16'h0034, 16'h00C7, 1'b0, 1'b1, 0, 1'b0);
    xfer(2'd3, 16'h0040, 16'h00D0, 1'b1, 1'b1, 0, 1'b0); // R1 bad size code
    xfer(2'd1, 16'h0041, 16'h00D2, 1'b1, 1'b0, 0, 1'b0); // odd src 2 bytes
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0]    rs;
      logic [AW-1:0] ra, rb;
      rs = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      ra = AW'($urandom % 120);
      rb = AW'(128 + $urandom % 120);
      if ($urandom % 4 != 0) begin
        ra = ra & ~AW'(3);
        rb = rb & ~AW'(3);
      end
      xfer(rs, ra, rb, 1'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule